// File: doc/BRIEF.md
# Partitioned Smart Victim Buffer

This block is a small fully associative buffer that sits between a core's private first-level cache and the shared second-level cache. Its storage is split into three regions. A victim region holds lines recently evicted from the first level. A stream region holds neighbour blocks that arrive with a second-level fill. A miss-history table keeps, for each recently missed block, a saturating count of its first-level misses. Lines that miss often stay resident through the replacement policy, so no line has to be locked in place.

The first level probes the buffer only when it misses. A probe carries the requested address and, optionally, the line the first level would displace. The lookup result is combinational: a hit flag, the region that hit, the line data and the block's miss count before this probe. At the next clock edge the buffer commits the hit. A victim-region hit swaps the displaced line into the hit slot. A stream-region hit frees its slot and moves the displaced line into the victim region. Evictions and neighbour fills come in on their own ports. Addresses are byte addresses and a block tag drops the line-offset bits, which are 7 bits for the default 128-byte line.

Top module: `smart_victim_buf`

## Requirements
- R1: While `lk_valid` is low, `lk_hit` is 0, `lk_region` is 0 and `lk_cnt` is 0, and no miss count changes.
- R2: A probe compares `lk_addr` with the address bits above the line offset against every valid line in both data regions in the same cycle. `lk_region` reads 1 for a victim hit, 2 for a stream hit and 0 for a miss. On a hit, `lk_data` carries the line data. The victim region wins if both regions match.
- R3: On a victim-region hit with `lk_swp_valid` high, the hit slot takes the displaced line given by `lk_swp_addr` and `lk_swp_data`. With `lk_swp_valid` low, the slot is freed.
- R4: On a stream-region hit, the slot is freed. If `lk_swp_valid` is high, the displaced line is inserted into the victim region.
- R5: An `ev_valid` pulse writes the line into the victim region. The lowest-numbered free slot is used first.
- R6: When the victim region is full, a line whose block miss count is below `hot_thr` is replaced in preference to a line at or above it. Among the candidates, the least recently written line goes first.
- R7: An `fl_valid` pulse writes a neighbour line into the stream region in strict FIFO order, overwriting the oldest insertion once the region is full.
- R8: `lk_cnt` reports the block's miss count before the probe. Each probe adds one, saturating at 2^CNT_W-1. A block not yet in the table reads 0 and starts at 1.
- R9: If `lk_valid` and `ev_valid` are high in the same cycle, the eviction is dropped.
- R10: Reset clears every valid bit and every miss count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Probe from a first-level miss |
| lk_addr | input | ADDR_W | Probed byte address |
| lk_swp_valid | input | 1 | A displaced first-level line accompanies the probe |
| lk_swp_addr | input | ADDR_W | Address of the displaced line |
| lk_swp_data | input | DATA_W | Data of the displaced line |
| lk_hit | output | 1 | Probe hit |
| lk_region | output | 2 | 0 none, 1 victim, 2 stream |
| lk_data | output | DATA_W | Hit line data |
| lk_cnt | output | CNT_W | Miss count of the probed block before this probe |
| ev_valid | input | 1 | First-level eviction into the victim region |
| ev_addr | input | ADDR_W | Evicted line address |
| ev_data | input | DATA_W | Evicted line data |
| fl_valid | input | 1 | Neighbour block from the next level |
| fl_addr | input | ADDR_W | Neighbour block address |
| fl_data | input | DATA_W | Neighbour block data |
| hot_thr | input | CNT_W | Miss count at which a victim line counts as hot |

## Verification
The assertions check on every cycle the properties that can be seen at the ports alone. These are: the quiet outputs when no probe is present, legal region codes that agree with the hit flag, the one-step saturating count across back-to-back probes of one block, the disappearance of a stream line after its hit, the presence of a swapped-in line one cycle later, and the cleared state after reset. The replacement choices need multi-step sequences, and only the bench's directed scenarios can show them. These are the preference for cold lines, least-recently-written order, FIFO overwrite in the stream region, and the dropping of an eviction that collides with a probe.

// File: rtl/svb_pkg.sv
package svb_pkg;
    typedef enum logic [1:0] {
        RG_NONE   = 2'd0,
        RG_VICTIM = 2'd1,
        RG_STREAM = 2'd2
    } region_e;

    function automatic int idx_bits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/svb_miss_table.sv
module svb_miss_table #(
    parameter int TAG_W = 25,
    parameter int ENT_N = 8,
    parameter int CNT_W = 3,
    parameter int NQ    = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        upd_valid,
    input  logic [TAG_W-1:0]            upd_tag,
    output logic [CNT_W-1:0]            upd_cnt,
    input  logic [NQ-1:0][TAG_W-1:0]    q_tags,
    output logic [NQ-1:0][CNT_W-1:0]    q_cnts
);
    localparam int IDX_W = svb_pkg::idx_bits(ENT_N);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic [ENT_N-1:0]              vld;
    logic [ENT_N-1:0][TAG_W-1:0]   tags;
    logic [ENT_N-1:0][CNT_W-1:0]   cnts;
    logic [IDX_W-1:0]              rr;

    logic             hit_any, free_any;
    logic [IDX_W-1:0] hit_idx, free_idx, alloc_idx;

    always_comb begin
        hit_any  = 1'b0;
        hit_idx  = '0;
        free_any = 1'b0;
        free_idx = '0;
        for (int i = 0; i < ENT_N; i++) begin
            if (!hit_any && vld[i] && tags[i] == upd_tag) begin
                hit_any = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (!free_any && !vld[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
        alloc_idx = free_any ? free_idx : rr;
        upd_cnt   = hit_any ? cnts[hit_idx] : '0;
    end

    always_comb begin
        for (int q = 0; q < NQ; q++) begin
            q_cnts[q] = '0;
            for (int i = 0; i < ENT_N; i++) begin
                if (vld[i] && tags[i] == q_tags[q]) q_cnts[q] = cnts[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld  <= '0;
            tags <= '0;
            cnts <= '0;
            rr   <= '0;
        end else if (upd_valid) begin
            if (hit_any) begin
                if (cnts[hit_idx] != CMAX) cnts[hit_idx] <= cnts[hit_idx] + 1'b1;
            end else begin
                vld[alloc_idx]  <= 1'b1;
                tags[alloc_idx] <= upd_tag;
                cnts[alloc_idx] <= CNT_W'(1);
                if (!free_any) rr <= (rr == IDX_W'(ENT_N - 1)) ? '0 : rr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/svb_victim_region.sv
module svb_victim_region #(
    parameter int TAG_W  = 25,
    parameter int DATA_W = 32,
    parameter int LINES  = 4,
    parameter int CNT_W  = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [TAG_W-1:0]              look_tag,
    output logic                          look_hit,
    output logic [DATA_W-1:0]             look_data,
    input  logic                          hit_act,
    input  logic                          sw_valid,
    input  logic [TAG_W-1:0]              sw_tag,
    input  logic [DATA_W-1:0]             sw_data,
    input  logic                          ins_valid,
    input  logic [TAG_W-1:0]              ins_tag,
    input  logic [DATA_W-1:0]             ins_data,
    input  logic [CNT_W-1:0]              thr,
    input  logic [LINES-1:0][CNT_W-1:0]   line_cnt,
    output logic [LINES-1:0][TAG_W-1:0]   line_tag
);
    localparam int IDX_W = svb_pkg::idx_bits(LINES);

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } line_t;

    logic [LINES-1:0]            vld;
    line_t [LINES-1:0]           mem;
    logic [LINES-1:0][IDX_W-1:0] age;

    logic [IDX_W-1:0] hidx, sel_idx, wr_idx;
    logic             free_any, have_cand, wr_en, clr_en;
    logic [LINES-1:0] cold, cand;
    line_t            wr_line;

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_tag
            assign line_tag[g] = mem[g].tag;
            assign cold[g]     = line_cnt[g] < thr;
        end
    endgenerate

    always_comb begin
        look_hit  = 1'b0;
        hidx      = '0;
        look_data = '0;
        for (int i = 0; i < LINES; i++) begin
            if (!look_hit && vld[i] && mem[i].tag == look_tag) begin
                look_hit  = 1'b1;
                hidx      = IDX_W'(i);
                look_data = mem[i].data;
            end
        end
    end

    always_comb begin
        free_any  = 1'b0;
        sel_idx   = '0;
        for (int i = 0; i < LINES; i++) begin
            if (!free_any && !vld[i]) begin
                free_any = 1'b1;
                sel_idx  = IDX_W'(i);
            end
        end
        cand      = (|cold) ? cold : {LINES{1'b1}};
        have_cand = 1'b0;
        if (!free_any) begin
            for (int i = 0; i < LINES; i++) begin
                if (cand[i] && (!have_cand || age[i] > age[sel_idx])) begin
                    have_cand = 1'b1;
                    sel_idx   = IDX_W'(i);
                end
            end
        end
    end

    always_comb begin
        wr_en   = 1'b0;
        clr_en  = 1'b0;
        wr_idx  = sel_idx;
        wr_line = '{tag: ins_tag, data: ins_data};
        if (hit_act && look_hit) begin
            wr_idx = hidx;
            if (sw_valid) begin
                wr_en   = 1'b1;
                wr_line = '{tag: sw_tag, data: sw_data};
            end else begin
                clr_en = 1'b1;
            end
        end else if (ins_valid) begin
            wr_en = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
            mem <= '0;
            for (int i = 0; i < LINES; i++) age[i] <= IDX_W'(i);
        end else begin
            if (clr_en) vld[wr_idx] <= 1'b0;
            if (wr_en) begin
                vld[wr_idx] <= 1'b1;
                mem[wr_idx] <= wr_line;
                for (int i = 0; i < LINES; i++) begin
                    if (IDX_W'(i) == wr_idx)      age[i] <= '0;
                    else if (age[i] < age[wr_idx]) age[i] <= age[i] + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/svb_stream_region.sv
module svb_stream_region #(
    parameter int TAG_W  = 25,
    parameter int DATA_W = 32,
    parameter int LINES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TAG_W-1:0]  look_tag,
    output logic              look_hit,
    output logic [DATA_W-1:0] look_data,
    input  logic              hit_act,
    input  logic              fill_valid,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data
);
    localparam int IDX_W = svb_pkg::idx_bits(LINES);

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } line_t;

    logic [LINES-1:0]  vld;
    line_t [LINES-1:0] mem;
    logic [IDX_W-1:0]  wp, hidx;

    always_comb begin
        look_hit  = 1'b0;
        hidx      = '0;
        look_data = '0;
        for (int i = 0; i < LINES; i++) begin
            if (!look_hit && vld[i] && mem[i].tag == look_tag) begin
                look_hit  = 1'b1;
                hidx      = IDX_W'(i);
                look_data = mem[i].data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
            mem <= '0;
            wp  <= '0;
        end else begin
            if (hit_act && look_hit) vld[hidx] <= 1'b0;
            if (fill_valid) begin
                vld[wp] <= 1'b1;
                mem[wp] <= '{tag: fill_tag, data: fill_data};
                wp      <= (wp == IDX_W'(LINES - 1)) ? '0 : wp + 1'b1;
            end
        end
    end
endmodule

// File: rtl/smart_victim_buf.sv
module smart_victim_buf #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 128,
    parameter int VIC_N      = 4,
    parameter int STR_N      = 4,
    parameter int MIS_N      = 8,
    parameter int CNT_W      = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_swp_valid,
    input  logic [ADDR_W-1:0] lk_swp_addr,
    input  logic [DATA_W-1:0] lk_swp_data,
    output logic              lk_hit,
    output logic [1:0]        lk_region,
    output logic [DATA_W-1:0] lk_data,
    output logic [CNT_W-1:0]  lk_cnt,
    input  logic              ev_valid,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [DATA_W-1:0] ev_data,
    input  logic              fl_valid,
    input  logic [ADDR_W-1:0] fl_addr,
    input  logic [DATA_W-1:0] fl_data,
    input  logic [CNT_W-1:0]  hot_thr
);
    import svb_pkg::*;

    localparam int OFS_W = $clog2(LINE_BYTES);
    localparam int TAG_W = ADDR_W - OFS_W;

    logic [TAG_W-1:0] lk_tag, swp_tag, ev_tag, fl_tag, ins_tag;
    logic             v_hit, s_hit, v_act, s_act, ins_valid;
    logic [DATA_W-1:0] v_data, s_data, ins_data;
    logic [CNT_W-1:0] cnt_now;
    logic [VIC_N-1:0][TAG_W-1:0] v_tags;
    logic [VIC_N-1:0][CNT_W-1:0] v_cnts;
    region_e          region;

    assign lk_tag  = lk_addr[ADDR_W-1:OFS_W];
    assign swp_tag = lk_swp_addr[ADDR_W-1:OFS_W];
    assign ev_tag  = ev_addr[ADDR_W-1:OFS_W];
    assign fl_tag  = fl_addr[ADDR_W-1:OFS_W];

    assign v_act = lk_valid && v_hit;
    assign s_act = lk_valid && s_hit && !v_hit;

    always_comb begin
        ins_valid = 1'b0;
        ins_tag   = ev_tag;
        ins_data  = ev_data;
        if (s_act) begin
            ins_valid = lk_swp_valid;
            ins_tag   = swp_tag;
            ins_data  = lk_swp_data;
        end else if (!lk_valid) begin
            ins_valid = ev_valid;
        end
    end

    always_comb begin
        region  = RG_NONE;
        lk_data = '0;
        if (v_act) begin
            region  = RG_VICTIM;
            lk_data = v_data;
        end else if (s_act) begin
            region  = RG_STREAM;
            lk_data = s_data;
        end
    end

    assign lk_region = region;
    assign lk_hit    = (region != RG_NONE);
    assign lk_cnt    = lk_valid ? cnt_now : '0;

    svb_miss_table #(
        .TAG_W(TAG_W), .ENT_N(MIS_N), .CNT_W(CNT_W), .NQ(VIC_N)
    ) u_miss (
        .clk(clk), .rst(rst),
        .upd_valid(lk_valid), .upd_tag(lk_tag), .upd_cnt(cnt_now),
        .q_tags(v_tags), .q_cnts(v_cnts)
    );

    svb_victim_region #(
        .TAG_W(TAG_W), .DATA_W(DATA_W), .LINES(VIC_N), .CNT_W(CNT_W)
    ) u_vic (
        .clk(clk), .rst(rst),
        .look_tag(lk_tag), .look_hit(v_hit), .look_data(v_data),
        .hit_act(v_act), .sw_valid(lk_swp_valid), .sw_tag(swp_tag), .sw_data(lk_swp_data),
        .ins_valid(ins_valid), .ins_tag(ins_tag), .ins_data(ins_data),
        .thr(hot_thr), .line_cnt(v_cnts), .line_tag(v_tags)
    );

    svb_stream_region #(
        .TAG_W(TAG_W), .DATA_W(DATA_W), .LINES(STR_N)
    ) u_str (
        .clk(clk), .rst(rst),
        .look_tag(lk_tag), .look_hit(s_hit), .look_data(s_data),
        .hit_act(s_act),
        .fill_valid(fl_valid), .fill_tag(fl_tag), .fill_data(fl_data)
    );
endmodule

// File: rtl/svb_checker.sv
module svb_checker #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 128,
    parameter int CNT_W      = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              lk_valid,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              lk_swp_valid,
    input logic [ADDR_W-1:0] lk_swp_addr,
    input logic [DATA_W-1:0] lk_swp_data,
    input logic              lk_hit,
    input logic [1:0]        lk_region,
    input logic [DATA_W-1:0] lk_data,
    input logic [CNT_W-1:0]  lk_cnt,
    input logic              ev_valid,
    input logic              fl_valid
);
    localparam int OFS_W = $clog2(LINE_BYTES);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic [ADDR_W-OFS_W-1:0] tag_now, swp_now;
    assign tag_now = lk_addr[ADDR_W-1:OFS_W];
    assign swp_now = lk_swp_addr[ADDR_W-1:OFS_W];

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> (!lk_hit && lk_region == 2'd0 && lk_cnt == '0)); // R1

    AST_REGION_LEGAL: assert property (@(posedge clk) disable iff (rst)
        lk_region != 2'd3 && (lk_hit == (lk_region != 2'd0))); // R2

    AST_SWAP_PRESENT: assert property (@(posedge clk) disable iff (rst)
        ($past(lk_valid && lk_region == 2'd1 && lk_swp_valid && swp_now != tag_now)
         && !$past(rst) && lk_valid && tag_now == $past(swp_now))
        |-> (lk_region == 2'd1 && lk_data == $past(lk_swp_data))); // R3

    AST_STREAM_FREED: assert property (@(posedge clk) disable iff (rst)
        ($past(lk_valid && lk_region == 2'd2 && !fl_valid) && !$past(rst)
         && lk_valid && tag_now == $past(tag_now))
        |-> (lk_region != 2'd2)); // R4

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        ($past(lk_valid) && !$past(rst) && lk_valid && tag_now == $past(tag_now))
        |-> (lk_cnt == (($past(lk_cnt) == CMAX) ? CMAX : $past(lk_cnt) + 1'b1))); // R8

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!lk_hit && lk_cnt == '0)); // R10
endmodule

bind smart_victim_buf svb_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES), .CNT_W(CNT_W)
) u_svb_chk (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_swp_valid(lk_swp_valid), .lk_swp_addr(lk_swp_addr), .lk_swp_data(lk_swp_data),
    .lk_hit(lk_hit), .lk_region(lk_region), .lk_data(lk_data), .lk_cnt(lk_cnt),
    .ev_valid(ev_valid), .fl_valid(fl_valid)
);

// File: tb/tb_smart_victim_buf.sv
module tb_smart_victim_buf;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lk_valid = 1'b0, lk_swp_valid = 1'b0;
    logic [AW-1:0] lk_addr = '0, lk_swp_addr = '0;
    logic [DW-1:0] lk_swp_data = '0;
    logic          lk_hit;
    logic [1:0]    lk_region;
    logic [DW-1:0] lk_data;
    logic [CW-1:0] lk_cnt;
    logic          ev_valid = 1'b0, fl_valid = 1'b0;
    logic [AW-1:0] ev_addr = '0, fl_addr = '0;
    logic [DW-1:0] ev_data = '0, fl_data = '0;
    logic [CW-1:0] hot_thr = 3'd7;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smart_victim_buf dut (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_swp_valid(lk_swp_valid), .lk_swp_addr(lk_swp_addr), .lk_swp_data(lk_swp_data),
        .lk_hit(lk_hit), .lk_region(lk_region), .lk_data(lk_data), .lk_cnt(lk_cnt),
        .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_data(ev_data),
        .fl_valid(fl_valid), .fl_addr(fl_addr), .fl_data(fl_data),
        .hot_thr(hot_thr)
    );

    function automatic logic [AW-1:0] blk(input int t, input int ofs);
        return (AW'(t) << 7) | AW'(ofs & 127);
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic evict(input int t, input logic [DW-1:0] d);
        @(negedge clk);
        ev_valid = 1'b1; ev_addr = blk(t, 5); ev_data = d;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic fill(input int t, input logic [DW-1:0] d);
        @(negedge clk);
        fl_valid = 1'b1; fl_addr = blk(t, 9); fl_data = d;
        @(negedge clk);
        fl_valid = 1'b0;
    endtask

    task automatic probe(input int t, input bit sv, input int st, input logic [DW-1:0] sd,
                         input logic [1:0] e_reg, input logic [DW-1:0] e_data,
                         input logic [CW-1:0] e_cnt, input string req);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = blk(t, 77);
        lk_swp_valid = sv; lk_swp_addr = blk(st, 3); lk_swp_data = sd;
        #1;
        check(lk_region == e_reg, {req, " region"}, 64'(lk_region), 64'(e_reg));
        check(lk_hit == (e_reg != 2'd0), {req, " hit"}, 64'(lk_hit), 64'(e_reg != 2'd0));
        if (e_reg != 2'd0) check(lk_data == e_data, {req, " data"}, 64'(lk_data), 64'(e_data));
        check(lk_cnt == e_cnt, {req, " count"}, 64'(lk_cnt), 64'(e_cnt));
        @(negedge clk);
        lk_valid = 1'b0; lk_swp_valid = 1'b0;
    endtask

    task automatic t_reset_and_idle();
        do_reset();
        #1;
        check(!lk_hit && lk_region == 2'd0 && lk_cnt == '0, "R10 reset outputs", 64'(lk_hit), 64'd0);
        evict(11, 32'hA11);
        @(negedge clk);
        lk_addr = blk(11, 0);
        #1;
        check(!lk_hit && lk_cnt == '0, "R1 idle quiet", 64'(lk_hit), 64'd0);
        @(negedge clk);
        probe(11, 0, 0, 0, 2'd1, 32'hA11, 3'd0, "R1 idle left count at 0");
        do_reset();
        probe(11, 0, 0, 0, 2'd0, 0, 3'd0, "R10 reset clears lines and counts");
    endtask

    task automatic t_victim_swap();
        do_reset();
        evict(20, 32'h2020);
        probe(20, 1, 21, 32'h2121, 2'd1, 32'h2020, 3'd0, "R2 R5 victim hit");
        probe(21, 0, 0, 0, 2'd1, 32'h2121, 3'd0, "R3 swapped line present");
        probe(20, 0, 0, 0, 2'd0, 0, 3'd1, "R3 hit line left buffer");
        probe(21, 0, 0, 0, 2'd0, 0, 3'd1, "R3 slot freed without swap");
    endtask

    task automatic t_stream();
        do_reset();
        fill(30, 32'h3030);
        probe(30, 1, 31, 32'h3131, 2'd2, 32'h3030, 3'd0, "R2 stream hit");
        probe(30, 0, 0, 0, 2'd0, 0, 3'd1, "R4 stream slot freed");
        probe(31, 0, 0, 0, 2'd1, 32'h3131, 3'd0, "R4 displaced line to victim");
        probe(99, 0, 0, 0, 2'd0, 0, 3'd0, "R2 plain miss");
    endtask

    task automatic t_stream_fifo();
        do_reset();
        for (int i = 0; i < 5; i++) fill(40 + i, 32'h4000 + i);
        probe(40, 0, 0, 0, 2'd0, 0, 3'd0, "R7 oldest overwritten");
        probe(44, 0, 0, 0, 2'd2, 32'h4004, 3'd0, "R7 newest present");
        probe(41, 0, 0, 0, 2'd2, 32'h4001, 3'd0, "R7 second oldest kept");
    endtask

    task automatic t_count_sat();
        do_reset();
        for (int i = 0; i < 10; i++) begin
            probe(50, 0, 0, 0, 2'd0, 0, (i > 7) ? 3'd7 : CW'(i), "R8 miss count step and saturation");
        end
    endtask

    task automatic t_lru_cold();
        do_reset();
        hot_thr = 3'd7;
        for (int i = 0; i < 4; i++) evict(60 + i, 32'h6000 + i);
        evict(64, 32'h6004);
        probe(60, 0, 0, 0, 2'd0, 0, 3'd0, "R6 LRU replaced oldest");
        probe(61, 0, 0, 0, 2'd1, 32'h6001, 3'd0, "R6 LRU kept next");
        probe(64, 0, 0, 0, 2'd1, 32'h6004, 3'd0, "R5 new line present");
    endtask

    task automatic t_hot_kept();
        do_reset();
        hot_thr = 3'd2;
        probe(70, 0, 0, 0, 2'd0, 0, 3'd0, "R8 first miss");
        probe(70, 0, 0, 0, 2'd0, 0, 3'd1, "R8 second miss");
        for (int i = 0; i < 4; i++) evict(70 + i, 32'h7000 + i);
        evict(74, 32'h7004);
        probe(71, 0, 0, 0, 2'd0, 0, 3'd0, "R6 cold line replaced");
        probe(70, 0, 0, 0, 2'd1, 32'h7000, 3'd2, "R6 hot line kept");
        hot_thr = 3'd7;
    endtask

    task automatic t_collision();
        do_reset();
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = blk(80, 0);
        ev_valid = 1'b1; ev_addr = blk(81, 0); ev_data = 32'h8181;
        @(negedge clk);
        lk_valid = 1'b0; ev_valid = 1'b0;
        probe(81, 0, 0, 0, 2'd0, 0, 3'd0, "R9 eviction dropped on collision");
    endtask

    initial begin
        do_reset();
        t_reset_and_idle();
        t_victim_swap();
        t_stream();
        t_stream_fifo();
        t_count_sat();
        t_lru_cold();
        t_hot_kept();
        t_collision();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule